// File: doc/BRIEF.md
# Card Memory Window Translator

This block sits between a host memory bus and a removable card slot. It gives software a small set of programmable memory windows, each covering a run of 4 KB pages of host address space. When a host access falls inside an enabled window, the block reports the hit. It forms the card address by adding a signed 14-bit page offset to the host page, wrapping modulo 2^14. It also presents that window's bus-width, wait-state, attribute-space and write-protect settings to the card-side timing logic.

Software programs the windows through a byte-wide write port and a combinational read-back port. Each window has a start page, an inclusive stop page, a page offset and, optionally, a high-byte register that matches host address bits 31:24. Its control flags share the upper bits of the 16-bit page registers. A single enable register holds one bit per window. The host-side decode is purely combinational, so the card-side sequencer sees the result in the same cycle as the host address.

Top module: `mwin_translator`

## Requirements
- R1: After a synchronous active-low reset, the enable register and every window byte read back as 0, and no host access hits.
- R2: Register map: the enable register is at address 0x00, with window w's enable in bit w and bits above the window count reading 0. Window w (0 to 4) has its bytes at 0x08*(w+1)+s: s=0 start[7:0], s=1 start hi, s=2 stop[7:0], s=3 stop hi, s=4 offset[7:0], s=5 offset hi, s=6 host address bits 31:24. A byte written at one of these addresses reads back unchanged at the same address on the following cycle.
- R3: A valid host access hits window w only when enable bit w is set and start <= host_addr[23:12] <= stop. Both bounds are inclusive, where start = {s1[3:0], s0} and stop = {s3[3:0], s2}.
- R4: A window also requires host_addr[31:24] to equal its s6 byte. With the high-byte option off, only addresses below 16 MB can hit.
- R5: On a hit, card_addr = {(host_addr[23:12] + {s5[5:0], s4}) mod 2^14, host_addr[11:0]}.
- R6: When several enabled windows hit, the lowest-numbered one wins, and win_idx gives its number.
- R7: On a hit, the outputs take the winning window's flags: card_bus16 = s1[7], card_zws = s1[6], card_ws = s3[7:6], card_attr = s5[6], card_wp = s5[7]. With no hit, card_addr and every flag output are 0.
- R8: A write that hits a window with s5[7] set drops card_req and raises prot_err for that access. A read of the same window raises card_req and leaves prot_err low.
- R9: A window whose enable bit is cleared and whose six page bytes are zero produces no hit for any address.
- R10: A window with a valid range does not hit while its enable bit is cleared.
- R11: With host_valid low, win_hit, card_req and prot_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read-back of reg_addr |
| host_valid | input | 1 | Host access present |
| host_write | input | 1 | Host access is a write |
| host_addr | input | 32 | Host byte address |
| win_hit | output | 1 | Some enabled window matches |
| win_idx | output | 3 | Number of the winning window |
| card_addr | output | 26 | Translated card byte address |
| card_bus16 | output | 1 | 16-bit data width for this access |
| card_zws | output | 1 | Zero-wait-state request |
| card_ws | output | 2 | Wait-state count |
| card_attr | output | 1 | Attribute-space select |
| card_wp | output | 1 | Window is write protected |
| card_req | output | 1 | Access forwarded to the card |
| prot_err | output | 1 | Write to a protected window, suppressed |

## Verification
The assertions assume that host_valid, host_write and host_addr are steady around each clock edge. They also assume that a register write and a host access to the same window do not need their relation checked within one cycle: a write takes effect on the next edge. The stimulus drives both ports on the falling edge, and checks the combinational outputs a quarter period later. Random window ranges stay within a small page region, and high bytes stay within a few values, so overlaps, boundary pages and high-byte mismatches occur often.

// File: rtl/mwin_pkg.sv
// Package: shared widths, register slot numbers and the window config type.
// Assumes 4 KB pages and a 24-bit page-plus-offset host space below the high byte.
package mwin_pkg;
    localparam int PAGE_W     = 12;               // host page bits 23:12
    localparam int OFF_W      = 14;               // card page / offset width
    localparam int BYTE_W     = 12;               // byte-in-page bits
    localparam int HI_W       = 8;                // host address bits 31:24
    localparam int CARD_AW    = OFF_W + BYTE_W;   // card byte address width
    localparam int SLOT_N     = 7;                // bytes used per window
    localparam int WIN_STRIDE = 8;                // address stride per window

    localparam int SL_START_LO = 0;
    localparam int SL_START_HI = 1;
    localparam int SL_STOP_LO  = 2;
    localparam int SL_STOP_HI  = 3;
    localparam int SL_OFF_LO   = 4;
    localparam int SL_OFF_HI   = 5;
    localparam int SL_HIGH     = 6;

    typedef struct packed {
        logic [PAGE_W-1:0] start;
        logic [PAGE_W-1:0] stop;
        logic [OFF_W-1:0]  offs;
        logic [HI_W-1:0]   hi;
        logic              bus16;
        logic              zws;
        logic [1:0]        ws;
        logic              attr;
        logic              wp;
    } win_cfg_t;
endpackage

// File: rtl/mwin_regfile.sv
// Module: byte-addressed window register bank plus the shared enable register.
// Assumes NUM_WIN <= 8 and REG_AW wide enough for (NUM_WIN+1)*WIN_STRIDE bytes.
module mwin_regfile
    import mwin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int REG_AW  = 6,
    parameter bit HIGH_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [REG_AW-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    output logic [NUM_WIN-1:0]       en_vec,
    output win_cfg_t [NUM_WIN-1:0]   cfg
);
    logic [7:0]         bank_q [NUM_WIN][SLOT_N];
    logic [NUM_WIN-1:0] en_q;

    // Store writes to the enable register and to window bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int w = 0; w < NUM_WIN; w++)
                for (int s = 0; s < SLOT_N; s++)
                    bank_q[w][s] <= '0;
        end else if (we) begin
            if (addr == '0)
                en_q <= wdata[NUM_WIN-1:0];
            for (int w = 0; w < NUM_WIN; w++)
                for (int s = 0; s < SLOT_N; s++)
                    if (addr == REG_AW'((w + 1) * WIN_STRIDE + s) &&
                        (s != SL_HIGH || HIGH_EN))
                        bank_q[w][s] <= wdata;
        end
    end

    // Read back the byte at addr; unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        if (addr == '0)
            rdata = 8'(en_q);
        for (int w = 0; w < NUM_WIN; w++)
            for (int s = 0; s < SLOT_N; s++)
                if (addr == REG_AW'((w + 1) * WIN_STRIDE + s))
                    rdata = bank_q[w][s];
    end

    assign en_vec = en_q;

    // Unpack each window's bytes into fields.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_unpack
        assign cfg[w].start = {bank_q[w][SL_START_HI][3:0], bank_q[w][SL_START_LO]};
        assign cfg[w].stop  = {bank_q[w][SL_STOP_HI][3:0],  bank_q[w][SL_STOP_LO]};
        assign cfg[w].offs  = {bank_q[w][SL_OFF_HI][5:0],   bank_q[w][SL_OFF_LO]};
        assign cfg[w].hi    = HIGH_EN ? bank_q[w][SL_HIGH] : '0;
        assign cfg[w].bus16 = bank_q[w][SL_START_HI][7];
        assign cfg[w].zws   = bank_q[w][SL_START_HI][6];
        assign cfg[w].ws    = bank_q[w][SL_STOP_HI][7:6];
        assign cfg[w].attr  = bank_q[w][SL_OFF_HI][6];
        assign cfg[w].wp    = bank_q[w][SL_OFF_HI][7];
    end
endmodule

// File: rtl/mwin_match.sv
// Module: range and high-byte compare for one window, plus its card page sum.
// Assumes the offset is a page count taken modulo 2^OFF_W.
module mwin_match
    import mwin_pkg::*;
(
    input  win_cfg_t           cfg,
    input  logic               en,
    input  logic               valid,
    input  logic [PAGE_W-1:0]  host_page,
    input  logic [HI_W-1:0]    host_hi,
    output logic               hit,
    output logic [OFF_W-1:0]   card_page
);
    // Inclusive page compare gated by enable and high byte.
    assign hit = valid && en && (host_page >= cfg.start) &&
                 (host_page <= cfg.stop) && (host_hi == cfg.hi);

    // Modular page translation.
    assign card_page = OFF_W'(host_page) + cfg.offs;
endmodule

// File: rtl/mwin_prio.sv
// Module: fixed priority pick, lowest-numbered request wins.
// Assumes N >= 2.
module mwin_prio #(
    parameter int N     = 5,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx
);
    // Isolate the lowest set request bit.
    assign gnt = req & (~req + N'(1));

    // Encode the granted position; scan downward so the lowest remains.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
    end
endmodule

// File: rtl/mwin_translator.sv
// Module: top of the card memory window translator.
// Programs windows through a byte port and decodes host accesses combinationally.
// Assumes host inputs are steady around each clock edge.
module mwin_translator
    import mwin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int REG_AW  = 6,
    parameter bit HIGH_EN = 1'b1,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [31:0]        host_addr,
    output logic               win_hit,
    output logic [IDX_W-1:0]   win_idx,
    output logic [CARD_AW-1:0] card_addr,
    output logic               card_bus16,
    output logic               card_zws,
    output logic [1:0]         card_ws,
    output logic               card_attr,
    output logic               card_wp,
    output logic               card_req,
    output logic               prot_err
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     en_vec;
    logic [NUM_WIN-1:0]     hit_vec;
    logic [NUM_WIN-1:0]     gnt;
    logic [OFF_W-1:0]       cpage [NUM_WIN];
    win_cfg_t               sel_cfg;
    logic [OFF_W-1:0]       sel_page;

    mwin_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .HIGH_EN(HIGH_EN)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en_vec(en_vec), .cfg(cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        mwin_match match_i (
            .cfg(cfg[w]), .en(en_vec[w]), .valid(host_valid),
            .host_page(host_addr[23:12]), .host_hi(host_addr[31:24]),
            .hit(hit_vec[w]), .card_page(cpage[w])
        );
    end

    mwin_prio #(.N(NUM_WIN), .IDX_W(IDX_W)) prio_i (
        .req(hit_vec), .gnt(gnt), .idx(win_idx)
    );

    // Steer the winning window's settings; zero when nothing hits.
    always_comb begin
        sel_cfg  = '0;
        sel_page = '0;
        for (int w = 0; w < NUM_WIN; w++)
            if (gnt[w]) begin
                sel_cfg  = cfg[w];
                sel_page = cpage[w];
            end
    end

    assign win_hit    = |hit_vec;
    assign card_addr  = win_hit ? {sel_page, host_addr[BYTE_W-1:0]} : '0;
    assign card_bus16 = sel_cfg.bus16;
    assign card_zws   = sel_cfg.zws;
    assign card_ws    = sel_cfg.ws;
    assign card_attr  = sel_cfg.attr;
    assign card_wp    = sel_cfg.wp;
    assign card_req   = win_hit && !(host_write && sel_cfg.wp);
    assign prot_err   = win_hit && host_write && sel_cfg.wp;
endmodule

// File: rtl/mwin_translator_chk.sv
// Module: property checker bound into mwin_translator.
module mwin_translator_chk #(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_valid,
    input logic               host_write,
    input logic [31:0]        host_addr,
    input logic               win_hit,
    input logic [IDX_W-1:0]   win_idx,
    input logic [25:0]        card_addr,
    input logic               card_bus16,
    input logic               card_attr,
    input logic               card_wp,
    input logic               card_req,
    input logic               prot_err,
    input logic [NUM_WIN-1:0] en_vec
);
    // R1
    reset_clears_enables_chk: assert property (@(posedge clk)
        !rst_n |=> (en_vec == '0));

    // R8
    prot_needs_wp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> (win_hit && host_write && card_wp));

    // R8
    prot_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> !card_req);

    // R7
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (card_addr == '0 && !card_bus16 && !card_attr && !card_req));

    // R11
    no_valid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |-> (!win_hit && !prot_err && !card_req));

    // R10
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ((en_vec >> win_idx) & NUM_WIN'(1)) != '0);

    // R5
    byte_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (card_addr[11:0] == host_addr[11:0]));
endmodule

bind mwin_translator mwin_translator_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .win_hit(win_hit), .win_idx(win_idx),
    .card_addr(card_addr), .card_bus16(card_bus16), .card_attr(card_attr),
    .card_wp(card_wp), .card_req(card_req), .prot_err(prot_err), .en_vec(en_vec)
);

// File: tb/mwin_translator_tb_top.sv
module mwin_translator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [31:0] host_addr = '0;
    logic        win_hit;
    logic [2:0]  win_idx;
    logic [25:0] card_addr;
    logic        card_bus16, card_zws, card_attr, card_wp, card_req, prot_err;
    logic [1:0]  card_ws;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_bank [NW][7];
    logic [7:0] m_en;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mwin_translator dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_valid(host_valid),
        .host_write(host_write), .host_addr(host_addr), .win_hit(win_hit),
        .win_idx(win_idx), .card_addr(card_addr), .card_bus16(card_bus16),
        .card_zws(card_zws), .card_ws(card_ws), .card_attr(card_attr),
        .card_wp(card_wp), .card_req(card_req), .prot_err(prot_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 6'd0) m_en = {3'b000, d[4:0]};
        else if (a >= 6'd8 && a < 6'd48 && a[2:0] < 3'd7) m_bank[a / 8 - 1][a[2:0]] = d;
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #(CLK_PERIOD / 4);
        check(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic prog_win(input int w, input logic [11:0] st, input logic [11:0] sp,
                            input logic [13:0] off, input logic [7:0] hi,
                            input logic [5:0] flags);
        // flags: {wp, attr, ws[1:0], zws, bus16}
        logic [5:0] b;
        b = 6'((w + 1) * 8);
        wr(b + 6'd0, st[7:0]);
        wr(b + 6'd1, {flags[0], flags[1], 2'b00, st[11:8]});
        wr(b + 6'd2, sp[7:0]);
        wr(b + 6'd3, {flags[3:2], 2'b00, sp[11:8]});
        wr(b + 6'd4, off[7:0]);
        wr(b + 6'd5, {flags[5], flags[4], off[13:8]});
        wr(b + 6'd6, hi);
    endtask

    task automatic access(input logic v, input logic wrt, input logic [31:0] a,
                          input string tag);
        logic ehit, ebus, ezws, eattr, ewp, ereq, eprot;
        logic [2:0] eidx;
        logic [1:0] ews;
        logic [25:0] eca;
        @(negedge clk);
        host_valid = v; host_write = wrt; host_addr = a;
        #(CLK_PERIOD / 4);
        {ehit, ebus, ezws, eattr, ewp} = '0; eidx = '0; ews = '0; eca = '0;
        for (int w = NW - 1; w >= 0; w--) begin
            logic [11:0] st, sp;
            logic [13:0] off;
            st  = {m_bank[w][1][3:0], m_bank[w][0]};
            sp  = {m_bank[w][3][3:0], m_bank[w][2]};
            off = {m_bank[w][5][5:0], m_bank[w][4]};
            if (v && m_en[w] && a[23:12] >= st && a[23:12] <= sp && a[31:24] == m_bank[w][6]) begin
                ehit = 1'b1; eidx = 3'(w);
                eca  = {14'({2'b00, a[23:12]} + off), a[11:0]};
                ebus = m_bank[w][1][7]; ezws = m_bank[w][1][6];
                ews  = m_bank[w][3][7:6];
                eattr = m_bank[w][5][6]; ewp = m_bank[w][5][7];
            end
        end
        ereq  = ehit && !(wrt && ewp);
        eprot = ehit && wrt && ewp;
        check(win_hit == ehit, {tag, " R3 hit"}, 32'(win_hit), 32'(ehit));
        if (ehit) check(win_idx == eidx, {tag, " R6 idx"}, 32'(win_idx), 32'(eidx));
        check(card_addr == eca, {tag, " R5 card_addr"}, 32'(card_addr), 32'(eca));
        check({card_bus16, card_zws, card_ws, card_attr, card_wp} ==
              {ebus, ezws, ews, eattr, ewp}, {tag, " R7 flags"},
              32'({card_bus16, card_zws, card_ws, card_attr, card_wp}),
              32'({ebus, ezws, ews, eattr, ewp}));
        check({card_req, prot_err} == {ereq, eprot}, {tag, " R8 req/prot"},
              32'({card_req, prot_err}), 32'({ereq, eprot}));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_en = '0;
        for (int w = 0; w < NW; w++) for (int s = 0; s < 7; s++) m_bank[w][s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check(6'd0, 8'h00, "R1 enable");
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < 7; s++) rd_check(6'((w + 1) * 8 + s), 8'h00, "R1 window byte");
        access(1'b1, 1'b0, 32'h0000_0000, "R1 after reset");

        // R2: readback
        wr(6'd27, 8'hA5);
        rd_check(6'd27, 8'hA5, "R2 byte readback");
        wr(6'd0, 8'hFF);
        rd_check(6'd0, 8'h1F, "R2 enable upper bits");
        wr(6'd27, 8'h00);
        wr(6'd0, 8'h00);

        // R3: inclusive bounds
        prog_win(0, 12'h100, 12'h10F, 14'h0200, 8'h00, 6'b00_0101);
        wr(6'd0, 8'h01);
        access(1'b1, 1'b0, 32'h000F_FFFF, "R3 below start");
        access(1'b1, 1'b0, 32'h0010_0000, "R3 at start");
        access(1'b1, 1'b0, 32'h0010_FFFF, "R3 at stop");
        access(1'b1, 1'b0, 32'h0011_0000, "R3 above stop");

        // R4: high byte
        access(1'b1, 1'b0, 32'h0110_0123, "R4 high mismatch");
        wr(6'd14, 8'h01);
        access(1'b1, 1'b0, 32'h0110_0123, "R4 high match");
        wr(6'd14, 8'h00);

        // R5: modular wrap of the card page
        wr(6'd12, 8'hF0); wr(6'd13, 8'h3F);
        access(1'b1, 1'b0, 32'h0010_5ABC, "R5 wrap");

        // R6: overlap priority
        prog_win(1, 12'h0F0, 12'h120, 14'h0010, 8'h00, 6'b01_1010);
        wr(6'd0, 8'h03);
        access(1'b1, 1'b0, 32'h0010_8000, "R6 lowest wins");
        wr(6'd0, 8'h02);
        access(1'b1, 1'b0, 32'h0010_8000, "R6 next window");

        // R8: write protect
        wr(6'd21, 8'h80);
        access(1'b1, 1'b1, 32'h0010_8004, "R8 write blocked");
        access(1'b1, 1'b0, 32'h0010_8004, "R8 read passes");

        // R10: disabled window with valid range
        wr(6'd0, 8'h00);
        access(1'b1, 1'b0, 32'h0010_0000, "R10 disabled");

        // R9: cleared and disabled window
        for (int s = 0; s < 7; s++) wr(6'(16 + s), 8'h00);
        for (int s = 0; s < 7; s++) wr(6'(8 + s), 8'h00);
        access(1'b1, 1'b0, 32'h0000_0000, "R9 page zero");
        access(1'b1, 1'b1, 32'h0010_0000, "R9 old range");
        access(1'b1, 1'b0, $urandom, "R9 random");

        // R11: no valid
        prog_win(2, 12'h000, 12'hFFF, 14'h0000, 8'h00, 6'b00_0000);
        wr(6'd0, 8'h04);
        access(1'b0, 1'b1, 32'h0012_3456, "R11 idle");

        // Random configurations and accesses
        for (int r = 0; r < 25; r++) begin
            for (int w = 0; w < NW; w++) begin
                logic [11:0] st;
                st = 12'($urandom_range(0, 60));
                prog_win(w, st, st + 12'($urandom_range(0, 15)), 14'($urandom),
                         8'($urandom_range(0, 1)), 6'($urandom));
            end
            wr(6'd0, 8'($urandom));
            for (int k = 0; k < 40; k++) begin
                logic [31:0] a;
                a = {8'($urandom_range(0, 2)), 12'($urandom_range(0, 80)), 12'($urandom)};
                access(1'($urandom_range(0, 7) != 0), 1'($urandom), a, "rand");
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule